// File: doc/BRIEF.md
# Address Line Alias Tester

This engine looks for broken address lines in a word-addressed memory. A broken line makes two addresses that differ only in that line reach the same storage word. The engine picks a reference ("anchor") word and walks a single set bit across a mask. Each step XORs the mask into the anchor to get a probe address. A probe that lies inside the region under test is used. A probe that lies outside the region is passed over and causes no memory access.

For each probe that is used, the engine does three accesses. It reads the probe word. It writes the bitwise inverse of that value to the anchor. It then reads the probe word again. If the second read returns the inverted value, the write to the anchor has landed in the probe's cell. The engine reports a failure and records the anchor, the probe and the mask.

A run has two sweeps. The first uses the region base as the anchor. The second uses the last word of the region. The engine stops at the first alias it finds, so a failure in the first sweep means the second sweep does not run. Every memory access uses a simple request/acknowledge port. The request is held until the memory acknowledges it, and read data comes back in the acknowledge cycle.

Top module: `addr_alias_tester`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `mem_req` are all 0.
- R2: In each sweep, the mask starts at address bit 0 and moves one position toward the MSB on each step, ending after bit AW-1. Each probe address is the anchor XOR the mask, so probes are handled in order of ascending mask bit.
- R3: A probe is used only if it is at or above `base_addr` and below `base_addr + size_words`. Any other probe causes no memory access.
- R4: For each probe that is used, the engine makes exactly three accesses, in this order: a read of the probe, a write of the bitwise inverse of that read data to the anchor, and a second read of the probe. The anchor is never read.
- R5: If the second probe read returns the value written to the anchor, the engine sets `fail`=1. It also sets `fail_taddr` to the anchor, `fail_probe` to the probe and `fail_mask` to the one-hot mask.
- R6: The first sweep uses `base_addr` as the anchor. The second sweep uses `base_addr + size_words - 1` (modulo 2^AW) as the anchor.
- R7: Once a fault is found, the run ends with no further memory access, and the second sweep is skipped.
- R8: While `mem_req` is 1 and `mem_ack` is 0, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R9: When a run ends, `done` goes to 1 with `busy` at 0, and `done` and `fail` hold until the next accepted start. A `start` pulse that arrives while `busy` is 1 is ignored. A run with `size_words`=0 makes no access and ends with `fail`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a run; accepted only while idle |
| base_addr | input | AW | First word of the region |
| size_words | input | AW+1 | Region length in words |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished; held until the next start |
| fail | output | 1 | The last run found an alias |
| fail_taddr | output | AW | Anchor address of the alias |
| fail_probe | output | AW | Probe address of the alias |
| fail_mask | output | AW | One-hot mask of the faulty line |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Acknowledge; accepts the current request |
| mem_rdata | input | DW | Read data, valid while `mem_ack` is 1 on a read |

## Verification
The range and anchor-address properties compare the memory port against `base_addr` and `size_words`. They therefore assume that these inputs do not change while `busy` is 1, even though the engine keeps its own copies. The bench changes region inputs only between runs, after `done` is seen. The bench also assumes that `mem_ack` is asserted only while a request is pending. Its responder raises the acknowledge only after it has seen `mem_req`, and it stretches that with a rotating latency of zero to two cycles. This tests the hold rule under both back-to-back and delayed acknowledges.

// File: rtl/addr_alias_tester.sv
module addr_alias_tester #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [AW:0]   size_words,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_taddr,
  output logic [AW-1:0] fail_probe,
  output logic [AW-1:0] fail_mask,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int EW = AW + 2;

  typedef enum logic [2:0] {ST_IDLE, ST_PROBE, ST_RD1, ST_WR, ST_RD2, ST_STEP} st_t;

  st_t           st;
  logic          sweep;
  logic [AW-1:0] base_q, anchor, mask;
  logic [AW:0]   size_q;
  logic [DW-1:0] wval;

  logic [AW-1:0] probe, last_a;
  logic [EW-1:0] lim;
  logic          in_rng;

  assign probe  = anchor ^ mask;
  assign lim    = EW'(base_q) + EW'(size_q);
  assign last_a = base_q + size_q[AW-1:0] - AW'(1);
  assign in_rng = (probe >= base_q) && (EW'(probe) < lim);

  assign busy      = (st != ST_IDLE);
  assign mem_req   = (st == ST_RD1) || (st == ST_WR) || (st == ST_RD2);
  assign mem_we    = (st == ST_WR);
  assign mem_addr  = (st == ST_WR) ? anchor : probe;
  assign mem_wdata = wval;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      sweep      <= 1'b0;
      base_q     <= '0;
      size_q     <= '0;
      anchor     <= '0;
      mask       <= '0;
      wval       <= '0;
      done       <= 1'b0;
      fail       <= 1'b0;
      fail_taddr <= '0;
      fail_probe <= '0;
      fail_mask  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          base_q     <= base_addr;
          size_q     <= size_words;
          anchor     <= base_addr;
          mask       <= AW'(1);
          sweep      <= 1'b0;
          done       <= 1'b0;
          fail       <= 1'b0;
          fail_taddr <= '0;
          fail_probe <= '0;
          fail_mask  <= '0;
          st         <= ST_PROBE;
        end
        ST_PROBE: st <= in_rng ? ST_RD1 : ST_STEP;
        ST_RD1: if (mem_ack) begin
          wval <= ~mem_rdata;
          st   <= ST_WR;
        end
        ST_WR: if (mem_ack) st <= ST_RD2;
        ST_RD2: if (mem_ack) begin
          if (mem_rdata == wval) begin
            fail       <= 1'b1;
            fail_taddr <= anchor;
            fail_probe <= probe;
            fail_mask  <= mask;
            done       <= 1'b1;
            st         <= ST_IDLE;
          end else begin
            st <= ST_STEP;
          end
        end
        ST_STEP: begin
          if (mask[AW-1]) begin
            if (!sweep) begin
              sweep  <= 1'b1;
              anchor <= last_a;
              mask   <= AW'(1);
              st     <= ST_PROBE;
            end else begin
              done <= 1'b1;
              st   <= ST_IDLE;
            end
          end else begin
            mask <= mask << 1;
            st   <= ST_PROBE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/addr_alias_tester_chk.sv
module addr_alias_tester_chk #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] base_addr,
  input logic [AW:0]   size_words,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic [AW-1:0] fail_taddr,
  input logic [AW-1:0] fail_probe,
  input logic [AW-1:0] fail_mask,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack
);
  logic [AW+1:0] c_lim;
  logic [AW-1:0] c_last;
  assign c_lim  = (AW+2)'(base_addr) + (AW+2)'(size_words);
  assign c_last = base_addr + size_words[AW-1:0] - AW'(1);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_alias_mask_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> ($countones(fail_mask) == 1) && ((fail_taddr ^ fail_probe) == fail_mask));

  assert_read_in_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr >= base_addr) && ((AW+2)'(mem_addr) < c_lim));

  assert_write_to_anchor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == base_addr) || (mem_addr == c_last));

  assert_fail_implies_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_start_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy && !done && !fail);
endmodule

bind addr_alias_tester addr_alias_tester_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
  .size_words(size_words), .busy(busy), .done(done), .fail(fail),
  .fail_taddr(fail_taddr), .fail_probe(fail_probe), .fail_mask(fail_mask),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/addr_alias_tester_bench.sv
module addr_alias_tester_bench;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [AW:0]   size_words = '0;
  logic          busy, done, fail;
  logic [AW-1:0] fail_taddr, fail_probe, fail_mask;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #2 clk = ~clk;

  addr_alias_tester #(.AW(AW), .DW(DW)) u_addr_alias_tester (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .size_words(size_words), .busy(busy), .done(done), .fail(fail),
    .fail_taddr(fail_taddr), .fail_probe(fail_probe), .fail_mask(fail_mask),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [DW-1:0] mem [N];
  logic [DW-1:0] ref_mem [N];
  bit flt_en = 0;
  int flt_bit = 0;

  bit            q_we[$];
  int            q_addr[$];
  logic [DW-1:0] q_wd[$];
  bit exp_fail;
  int exp_ft, exp_fp, exp_fm;

  function automatic int phys(input int a);
    return flt_en ? (a & ~(1 << flt_bit)) : a;
  endfunction

  task automatic build(input int b, input int s);
    int t, p;
    logic [DW-1:0] w;
    q_we.delete(); q_addr.delete(); q_wd.delete();
    for (int i = 0; i < N; i++) ref_mem[i] = mem[i];
    exp_fail = 0; exp_ft = 0; exp_fp = 0; exp_fm = 0;
    for (int sw = 0; sw < 2; sw++) begin
      if (!exp_fail) begin
        t = (sw == 0) ? b : ((b + s - 1) & (N - 1));
        for (int k = 0; k < AW; k++) begin
          if (!exp_fail) begin
            p = t ^ (1 << k);
            if (p >= b && p < b + s) begin
              w = ~ref_mem[phys(p)];
              q_we.push_back(0); q_addr.push_back(p); q_wd.push_back('0);
              q_we.push_back(1); q_addr.push_back(t); q_wd.push_back(w);
              ref_mem[phys(t)] = w;
              q_we.push_back(0); q_addr.push_back(p); q_wd.push_back('0);
              if (ref_mem[phys(p)] == w) begin
                exp_fail = 1; exp_ft = t; exp_fp = p; exp_fm = 1 << k;
              end
            end
          end
        end
      end
    end
  endtask

  // memory responder and per-access comparison against the reference sequence
  initial begin
    int wcnt = 0;
    int lat = 0;
    forever begin
      @(negedge clk);
      if (!rst_n || !mem_req) begin
        mem_ack = 1'b0; wcnt = 0;
      end else if (wcnt >= lat) begin
        mem_ack = 1'b1; wcnt = 0; lat = (lat + 1) % 3;
        if (q_we.size() == 0) begin
          chk(0, "R7", "unexpected access addr", int'(mem_addr), -1);
        end else begin
          // R2 R3 R4 R6: order, kind, address and data of every access
          chk(mem_we == q_we[0], "R4", "access kind", mem_we, q_we[0]);
          chk(int'(mem_addr) == q_addr[0], "R2", "access address", mem_addr, q_addr[0]);
          if (mem_we) chk(mem_wdata == q_wd[0], "R4", "write data", mem_wdata, q_wd[0]);
          void'(q_we.pop_front()); void'(q_addr.pop_front()); void'(q_wd.pop_front());
        end
        if (mem_we) mem[phys(int'(mem_addr))] = mem_wdata;
        else mem_rdata = mem[phys(int'(mem_addr))];
      end else begin
        mem_ack = 1'b0; wcnt++;
      end
    end
  end

  task automatic run(input int b, input int s, input bit fen, input int fb,
                     input bit poke, input int seed, input string tag);
    int cyc = 0;
    flt_en = fen; flt_bit = fb;
    for (int i = 0; i < N; i++) mem[i] = (i * 32'h9E3779B9) ^ seed;
    build(b, s);
    @(negedge clk);
    base_addr = AW'(b); size_words = (AW+1)'(s);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R9", {tag, " start accepted"}, {busy, done}, 2'b10);
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 7) start = 1'b1;
      if (poke && cyc == 8) start = 1'b0;
    end
    chk(cyc < 20000, "R9", {tag, " timeout"}, cyc, 20000);
    chk(!busy, "R9", {tag, " busy at done"}, busy, 0);
    chk(q_we.size() == 0, "R6", {tag, " accesses remaining"}, q_we.size(), 0);
    chk(fail == exp_fail, "R5", {tag, " fail"}, fail, exp_fail);
    if (exp_fail) begin
      chk(int'(fail_taddr) == exp_ft, "R5", {tag, " fail_taddr"}, fail_taddr, exp_ft);
      chk(int'(fail_probe) == exp_fp, "R5", {tag, " fail_probe"}, fail_probe, exp_fp);
      chk(int'(fail_mask) == exp_fm, "R5", {tag, " fail_mask"}, fail_mask, exp_fm);
    end
    repeat (5) @(negedge clk);
    chk(done && fail == exp_fail && !mem_req, "R9", {tag, " result held"},
        {done, fail}, {1'b1, exp_fail});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, fail, mem_req} == 4'b0, "R1", "reset outputs",
        {busy, done, fail, mem_req}, 0);
    rst_n = 1'b1;
    run(0, 256, 0, 0, 0, 32'h1111, "R6 full clean");
    run(8'h10, 8'h30, 0, 0, 0, 32'h2222, "R3 partial clean");
    run(0, 256, 1, 3, 0, 32'h3333, "R7 alias bit3");
    run(0, 256, 1, 0, 0, 32'h4444, "R5 alias bit0");
    run(8'h40, 8'h10, 1, 5, 0, 32'h5555, "R3 alias outside");
    run(8'h20, 8'h60, 1, 6, 1, 32'h6666, "R9 poke alias bit6");
    run(8'h37, 8'h2B, 0, 0, 1, 32'h7777, "R2 odd region");
    run(8'h80, 0, 0, 0, 0, 32'h8888, "R9 empty region");
    run(8'hC0, 8'h40, 1, 4, 0, 32'h9999, "R6 top region bit4");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog expired: actual 150000 cycles expected fewer");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule